// File: doc/BRIEF.md
# Weighted Fair Queuing Rank Calculator

This block assigns a scheduling rank to every arriving packet so that a downstream sorted queue, which always releases its smallest rank first, serves flows in weighted fair order. Each packet arrives with a flow number, a length, the reciprocal of its flow's weight and the current system virtual time. The block holds one finish tag per flow. A packet starts at whichever is later: its flow's last finish tag or the virtual time. That start tag becomes the packet's rank. The flow's finish tag then moves forward by the length scaled by the reciprocal weight.

The block accepts one packet in every cycle. It reads the flow's tag, updates it and writes it back in that same cycle, so a packet that follows another of the same flow on the next cycle already sees the new tag. Rank, flow number and a valid strobe are registered and appear one cycle after the input. Flow classification, the advance of virtual time and the sorted queue itself are outside the block.

Top module: `wfq_rank_calc`

## Requirements
- R1: After reset, out_valid is low and every flow's finish tag is zero. The first packet of any flow therefore gets its own virtual time as its rank.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low otherwise. out_flow then repeats that packet's in_flow.
- R3: The rank of a packet is the larger of its flow's finish tag and in_vtime. It is therefore never below in_vtime, and it equals in_vtime when the two are equal.
- R4: A packet sets its flow's finish tag to its rank plus floor(in_len * in_inv_weight / 256). in_inv_weight is unsigned fixed point with 8 fraction bits, so 256 means weight 1.
- R5: A packet of the same flow on the very next cycle uses the finish tag just written by the previous packet.
- R6: A packet changes only its own flow's finish tag. Other flows are left as they were.
- R7: While in_valid is low, no finish tag changes, whatever is on the other inputs, and out_rank holds its value.
- R8: Finish tags are kept modulo 2^TIME_W, so an update past the top wraps around to a small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A packet is presented this cycle |
| in_flow | input | FLOW_W | Flow number of the packet |
| in_len | input | LEN_W | Packet length |
| in_inv_weight | input | RECIP_W | Reciprocal of the flow weight, FRAC fraction bits |
| in_vtime | input | TIME_W | Current system virtual time |
| out_valid | output | 1 | Rank of the previous cycle's packet is valid |
| out_rank | output | TIME_W | Rank (virtual start tag) of that packet |
| out_flow | output | FLOW_W | Flow number of that packet |

## Verification
Two operations can fall in the same cycle. One packet writes its flow's new finish tag, and the next packet of that same flow reads that tag. The bench provokes this by issuing bursts of one flow on consecutive cycles with no idle cycle between them. It also mixes flows inside a burst, so a read of one flow meets a write to another. It judges the result from the ranks: each rank in a same-flow burst must equal the previous rank plus the scaled length. A stale read would instead return the tag from before the burst.

// File: rtl/wfq_rank_calc.sv
module wfq_rank_calc #(
  parameter int FLOW_W  = 3,
  parameter int LEN_W   = 12,
  parameter int TIME_W  = 24,
  parameter int RECIP_W = 16,
  parameter int FRAC    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [RECIP_W-1:0] in_inv_weight,
  input  logic [TIME_W-1:0] in_vtime,
  output logic              out_valid,
  output logic [TIME_W-1:0] out_rank,
  output logic [FLOW_W-1:0] out_flow
);
  localparam int NFLOWS = 1 << FLOW_W;
  localparam int PROD_W = LEN_W + RECIP_W;

  logic [TIME_W-1:0] fin_tab [NFLOWS];

  wire [TIME_W-1:0] last_fin = fin_tab[in_flow];
  wire [TIME_W-1:0] start_tag = (last_fin > in_vtime) ? last_fin : in_vtime;
  wire [PROD_W-1:0] prod = PROD_W'(in_len) * PROD_W'(in_inv_weight);
  wire [PROD_W-1:0] span = prod >> FRAC;
  wire [TIME_W-1:0] next_fin = start_tag + TIME_W'(span);

  for (genvar g = 0; g < NFLOWS; g++) begin : g_fin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fin_tab[g] <= '0;
      else if (in_valid && in_flow == FLOW_W'(g))
        fin_tab[g] <= next_fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rank  <= '0;
      out_flow  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rank <= start_tag;
        out_flow <= in_flow;
      end
    end
  end
endmodule

module wfq_rank_calc_chk #(
  parameter int FLOW_W = 3,
  parameter int TIME_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [FLOW_W-1:0] in_flow,
  input logic [TIME_W-1:0] in_vtime,
  input logic              out_valid,
  input logic [TIME_W-1:0] out_rank,
  input logic [FLOW_W-1:0] out_flow
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_FLOW_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_flow == $past(in_flow)); // R2
  AST_RANK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_rank >= $past(in_vtime)); // R3
  AST_RANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_rank)); // R7
endmodule

bind wfq_rank_calc wfq_rank_calc_chk #(.FLOW_W(FLOW_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flow(in_flow),
  .in_vtime(in_vtime), .out_valid(out_valid), .out_rank(out_rank),
  .out_flow(out_flow)
);

// File: tb/tb_wfq_rank_calc.sv
module tb_wfq_rank_calc;
  localparam int FLOW_W = 3, LEN_W = 12, TIME_W = 24, RECIP_W = 16;
  localparam int NFLOWS = 1 << FLOW_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [FLOW_W-1:0] in_flow = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic [RECIP_W-1:0] in_inv_weight = '0;
  logic [TIME_W-1:0] in_vtime = '0;
  logic out_valid;
  logic [TIME_W-1:0] out_rank;
  logic [FLOW_W-1:0] out_flow;

  int errors = 0, checks = 0;
  logic [TIME_W-1:0] model_fin [NFLOWS];
  logic [TIME_W-1:0] last_rank;

  wfq_rank_calc dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one packet, one cycle; checks rank, strobe and flow right after the edge
  task automatic issue(input string req, input int f, input int len, input int inv, input int vt);
    logic [TIME_W-1:0] st;
    @(negedge clk);
    in_valid = 1'b1; in_flow = FLOW_W'(f); in_len = LEN_W'(len);
    in_inv_weight = RECIP_W'(inv); in_vtime = TIME_W'(vt);
    st = (model_fin[f] > TIME_W'(vt)) ? model_fin[f] : TIME_W'(vt);
    model_fin[f] = st + TIME_W'((len * inv) >> 8);
    @(posedge clk); #1;
    check({req, " valid"}, 32'(out_valid), 1);
    check({req, " flow"}, 32'(out_flow), 32'(f));
    check({req, " rank"}, 32'(out_rank), 32'(st));
    last_rank = st;
  endtask

  task automatic idle(input int f, input int len, input int vt);
    @(negedge clk);
    in_valid = 1'b0; in_flow = FLOW_W'(f); in_len = LEN_W'(len);
    in_inv_weight = 16'hFFFF; in_vtime = TIME_W'(vt);
    @(posedge clk); #1;
    check("R2 idle valid", 32'(out_valid), 0);
    check("R7 rank held", 32'(out_rank), 32'(last_rank));
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset valid", 32'(out_valid), 0);
    issue("R1 first flow3", 3, 100, 256, 77);
    issue("R1 first flow6", 6, 10, 256, 0);
  endtask

  task automatic t_start_rule();
    issue("R3 vtime wins", 0, 256, 256, 100);   // finish 356
    issue("R3 finish wins", 0, 20, 512, 50);    // rank 356, finish 396
    issue("R3 equal", 0, 8, 256, 396);
    issue("R3 vtime later", 0, 1, 256, 1000);
  endtask

  task automatic t_scaling();
    issue("R4 sub-unit span", 1, 3, 85, 0);     // span 0
    issue("R4 truncated", 1, 10, 300, 0);       // span 11
    issue("R4 half weight", 1, 100, 512, 0);    // span 200
    issue("R4 check", 1, 0, 0, 0);
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) issue("R5 burst", 2, 100, 128, 0);
    issue("R5 interleave a", 4, 40, 256, 5);
    issue("R5 interleave b", 2, 40, 256, 5);
    issue("R6 other flow", 4, 40, 256, 5);
  endtask

  task automatic t_ignore();
    idle(2, 4000, 9999);
    idle(5, 4000, 0);
    issue("R7 table kept", 2, 1, 256, 0);
    issue("R6 untouched flow", 7, 1, 256, 3);
  endtask

  task automatic t_wrap();
    issue("R8 near top", 5, 40, 256, (1 << TIME_W) - 10);
    issue("R8 wrapped", 5, 1, 256, 0);          // rank 30
    check("R8 wrapped value", 32'(last_rank), 30);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NFLOWS; i++) model_fin[i] = '0;
    last_rank = '0;
    repeat (3) @(posedge clk);
    t_reset_pre: begin
      #1;
      check("R1 in reset valid", 32'(out_valid), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_start_rule();
    t_scaling();
    t_burst();
    t_ignore();
    t_wrap();
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R2 drop", 32'(out_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule